// File: doc/BRIEF.md
# Issue Queue with Tag Wakeup

This block holds renamed instructions between rename and execution in an out-of-order core. Each cycle up to `INS_W` instructions arrive in program order, each with an operation class, a destination physical tag, two source physical tags with a per-source ready flag, and an age sequence number. An entry waits until both of its sources are ready, then competes for one of `ISS_W` issue slots. Among the competitors, the oldest win.

Readiness comes from tag broadcast. Each completing instruction drives its destination tag on one of `WK_N` wakeup ports. Every stored source holding that tag becomes ready, and so does a source of an instruction being inserted in the same cycle. A result marked as a load wakes its consumers one cycle later than a plain ALU result. A stored source tag is never rewritten, so retirement of the producer does not affect the entry.

A mispredicted branch drives a flush with its own sequence number. Every entry younger than that point is dropped at once and is masked from issue in the same cycle.

Top module: `iq_wakeup_select`

## Requirements
- R1: After reset, all issue slots are invalid, and `full_o` is low while no lane requests insertion.
- R2: A group of n valid insertion lanes is accepted only when n is no larger than the number of unoccupied entries. Otherwise `full_o` is high in that cycle and no lane of the group enters the queue.
- R3: A source flagged ready at insertion needs no broadcast. An entry inserted with both sources ready can issue in the next cycle.
- R4: A broadcast with `wk_load_i` low in cycle t sets every stored source holding that tag to ready, so the entry can issue in cycle t+1.
- R5: A broadcast with `wk_load_i` high in cycle t takes effect one cycle later, so a dependent entry issues no earlier than cycle t+2.
- R6: A broadcast is also compared against the sources of lanes being inserted in the same cycle. A lane woken this way can issue in the next cycle.
- R7: At most `ISS_W` entries with both sources ready issue per cycle, chosen oldest first. A ready entry goes ahead of older entries that are not ready. Slot 0 carries the oldest chosen entry, and the slots fill contiguously in increasing age. Sequence a is older than b when (a-b) mod 2^SEQ_W has its top bit set.
- R8: An issued entry leaves the queue at the end of its issue cycle and never issues again.
- R9: With `flush_i` high, every entry whose sequence number is younger than `flush_seq_i` is removed and is not issued, even in that cycle. The entry at the flush point and older entries remain. Insertions in the flush cycle are dropped.
- R10: The issue slot outputs carry the operation class, destination tag, source tags and sequence number exactly as they were inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | INS_W | Insertion lane valid |
| ins_op_i | input | INS_W x OP_W | Operation class per lane |
| ins_dst_i | input | INS_W x TAG_W | Destination tag per lane |
| ins_src0_i | input | INS_W x TAG_W | First source tag per lane |
| ins_rdy0_i | input | INS_W | First source already available |
| ins_src1_i | input | INS_W x TAG_W | Second source tag per lane |
| ins_rdy1_i | input | INS_W | Second source already available |
| ins_seq_i | input | INS_W x SEQ_W | Age sequence number per lane |
| full_o | output | 1 | Insertion group refused |
| wk_valid_i | input | WK_N | Wakeup broadcast valid |
| wk_load_i | input | WK_N | Broadcast comes from a load (one extra cycle) |
| wk_tag_i | input | WK_N x TAG_W | Broadcast destination tag |
| flush_i | input | 1 | Remove entries younger than the flush point |
| flush_seq_i | input | SEQ_W | Sequence number of the flush point |
| iss_valid_o | output | ISS_W | Issue slot valid |
| iss_op_o | output | ISS_W x OP_W | Issued operation class |
| iss_dst_o | output | ISS_W x TAG_W | Issued destination tag |
| iss_src0_o | output | ISS_W x TAG_W | Issued first source tag |
| iss_src1_o | output | ISS_W x TAG_W | Issued second source tag |
| iss_seq_o | output | ISS_W x SEQ_W | Issued sequence number |

## Verification
The bench builds the queue with 8 entries, 4 insertion lanes, 4 issue slots, 2 wakeup ports, 6-bit tags and 6-bit sequence numbers. With these values two full insertion groups fill the queue, so the refusal path is reached often. Four issue slots against eight entries exercise partial select, where some ready entries are left waiting. The 6-bit sequence counter wraps many times during the random phase, which tests the modular age comparison in both select and flush. The random phase draws source tags from 16 values, so the two wakeup ports produce frequent matches on several entries at once, including matches on lanes inserted in the same cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned OP_W = 2;

  typedef logic [OP_W-1:0] op_t;

  // a is older than b when (a-b) has its top bit set within a w-bit window
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction
endpackage

// File: rtl/iq_wake.sv
module iq_wake #(
  parameter int unsigned WK_N  = 2,
  parameter int unsigned TAG_W = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [WK_N-1:0]                  wk_valid_i,
  input  logic [WK_N-1:0]                  wk_load_i,
  input  logic [WK_N-1:0][TAG_W-1:0]       wk_tag_i,
  output logic [2*WK_N-1:0]                eff_valid_o,
  output logic [2*WK_N-1:0][TAG_W-1:0]     eff_tag_o
);
  logic [WK_N-1:0]            ld_q;
  logic [WK_N-1:0][TAG_W-1:0] ld_tag_q;

  // load results are held one cycle before they wake consumers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q     <= '0;
      ld_tag_q <= '0;
    end else begin
      ld_q     <= wk_valid_i & wk_load_i;
      ld_tag_q <= wk_tag_i;
    end
  end

  for (genvar j = 0; j < WK_N; j++) begin : g_port
    assign eff_valid_o[j]      = wk_valid_i[j] & ~wk_load_i[j];
    assign eff_tag_o[j]        = wk_tag_i[j];
    assign eff_valid_o[WK_N+j] = ld_q[j];
    assign eff_tag_o[WK_N+j]   = ld_tag_q[j];
  end
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter  int unsigned DEPTH  = 8,
  parameter  int unsigned INS_W  = 4,
  localparam int unsigned LANE_W = (INS_W > 1) ? $clog2(INS_W) : 1
) (
  input  logic [DEPTH-1:0]             used_i,
  input  logic [INS_W-1:0]             req_i,
  output logic                         full_o,
  output logic [DEPTH-1:0]             take_o,
  output logic [DEPTH-1:0][LANE_W-1:0] lane_o
);
  int free_rank [DEPTH];
  int lane_rank [INS_W];
  int n_free;
  int n_req;

  // k-th requesting lane lands in k-th free entry
  always_comb begin
    n_free = 0;
    for (int e = 0; e < DEPTH; e++) begin
      free_rank[e] = n_free;
      if (!used_i[e]) n_free++;
    end
    n_req = 0;
    for (int l = 0; l < INS_W; l++) begin
      lane_rank[l] = n_req;
      if (req_i[l]) n_req++;
    end
    full_o = n_req > n_free;
    take_o = '0;
    lane_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      for (int l = 0; l < INS_W; l++) begin
        if (!used_i[e] && req_i[l] && lane_rank[l] == free_rank[e]) begin
          take_o[e] = 1'b1;
          lane_o[e] = LANE_W'(l);
        end
      end
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned ISS_W = 4,
  parameter  int unsigned SEQ_W = 6,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            cand_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
  output logic [DEPTH-1:0]            pick_o,
  output logic [ISS_W-1:0]            slot_vld_o,
  output logic [ISS_W-1:0][IDX_W-1:0] slot_idx_o
);
  int rank [DEPTH];

  // rank = number of older candidates; rank < ISS_W wins slot rank
  always_comb begin
    pick_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      rank[e] = 0;
      for (int f = 0; f < DEPTH; f++) begin
        if (f != e && cand_i[f] &&
            seq_older(32'(seq_i[f]), 32'(seq_i[e]), SEQ_W)) rank[e]++;
      end
      pick_o[e] = cand_i[e] && (rank[e] < int'(ISS_W));
    end
    slot_vld_o = '0;
    slot_idx_o = '0;
    for (int k = 0; k < ISS_W; k++) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (pick_o[e] && rank[e] == k) begin
          slot_vld_o[k] = 1'b1;
          slot_idx_o[k] = IDX_W'(e);
        end
      end
    end
  end
endmodule

// File: rtl/iq_wakeup_select.sv
module iq_wakeup_select
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned INS_W = 4,
  parameter int unsigned ISS_W = 4,
  parameter int unsigned WK_N  = 2,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned SEQ_W = 6
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [INS_W-1:0]                ins_valid_i,
  input  logic [INS_W-1:0][OP_W-1:0]      ins_op_i,
  input  logic [INS_W-1:0][TAG_W-1:0]     ins_dst_i,
  input  logic [INS_W-1:0][TAG_W-1:0]     ins_src0_i,
  input  logic [INS_W-1:0]                ins_rdy0_i,
  input  logic [INS_W-1:0][TAG_W-1:0]     ins_src1_i,
  input  logic [INS_W-1:0]                ins_rdy1_i,
  input  logic [INS_W-1:0][SEQ_W-1:0]     ins_seq_i,
  output logic                            full_o,
  input  logic [WK_N-1:0]                 wk_valid_i,
  input  logic [WK_N-1:0]                 wk_load_i,
  input  logic [WK_N-1:0][TAG_W-1:0]      wk_tag_i,
  input  logic                            flush_i,
  input  logic [SEQ_W-1:0]                flush_seq_i,
  output logic [ISS_W-1:0]                iss_valid_o,
  output logic [ISS_W-1:0][OP_W-1:0]      iss_op_o,
  output logic [ISS_W-1:0][TAG_W-1:0]     iss_dst_o,
  output logic [ISS_W-1:0][TAG_W-1:0]     iss_src0_o,
  output logic [ISS_W-1:0][TAG_W-1:0]     iss_src1_o,
  output logic [ISS_W-1:0][SEQ_W-1:0]     iss_seq_o
);
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LANE_W = (INS_W > 1) ? $clog2(INS_W) : 1;
  localparam int unsigned BC_N   = 2 * WK_N;

  logic [DEPTH-1:0]            used_q, r0_q, r1_q;
  op_t  [DEPTH-1:0]            op_q;
  logic [DEPTH-1:0][TAG_W-1:0] dst_q, s0_q, s1_q;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;

  logic [BC_N-1:0]             bc_vld;
  logic [BC_N-1:0][TAG_W-1:0]  bc_tag;
  logic [DEPTH-1:0]            hit0, hit1, kill, cand, pick, take;
  logic [INS_W-1:0]            lhit0, lhit1;
  logic [DEPTH-1:0][LANE_W-1:0] lane;
  logic [ISS_W-1:0][IDX_W-1:0] slot_idx;
  logic                        full, wr_en;

  iq_wake #(.WK_N(WK_N), .TAG_W(TAG_W)) u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wk_valid_i (wk_valid_i),
    .wk_load_i  (wk_load_i),
    .wk_tag_i   (wk_tag_i),
    .eff_valid_o(bc_vld),
    .eff_tag_o  (bc_tag)
  );

  iq_alloc #(.DEPTH(DEPTH), .INS_W(INS_W)) u_alloc (
    .used_i(used_q),
    .req_i (ins_valid_i),
    .full_o(full),
    .take_o(take),
    .lane_o(lane)
  );

  iq_select #(.DEPTH(DEPTH), .ISS_W(ISS_W), .SEQ_W(SEQ_W)) u_sel (
    .cand_i    (cand),
    .seq_i     (seq_q),
    .pick_o    (pick),
    .slot_vld_o(iss_valid_o),
    .slot_idx_o(slot_idx)
  );

  // tag match for stored entries and for lanes entering this cycle
  always_comb begin
    hit0  = '0;
    hit1  = '0;
    lhit0 = '0;
    lhit1 = '0;
    for (int j = 0; j < BC_N; j++) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (bc_vld[j] && bc_tag[j] == s0_q[e]) hit0[e] = 1'b1;
        if (bc_vld[j] && bc_tag[j] == s1_q[e]) hit1[e] = 1'b1;
      end
      for (int l = 0; l < INS_W; l++) begin
        if (bc_vld[j] && bc_tag[j] == ins_src0_i[l]) lhit0[l] = 1'b1;
        if (bc_vld[j] && bc_tag[j] == ins_src1_i[l]) lhit1[l] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      kill[e] = flush_i && used_q[e] &&
                seq_older(32'(flush_seq_i), 32'(seq_q[e]), SEQ_W);
    end
  end

  assign cand   = used_q & r0_q & r1_q & ~kill;
  assign full_o = full;
  assign wr_en  = !full && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      r0_q   <= '0;
      r1_q   <= '0;
      op_q   <= '0;
      dst_q  <= '0;
      s0_q   <= '0;
      s1_q   <= '0;
      seq_q  <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (pick[e] || kill[e]) begin
          used_q[e] <= 1'b0;
        end else if (used_q[e]) begin
          r0_q[e] <= r0_q[e] | hit0[e];
          r1_q[e] <= r1_q[e] | hit1[e];
        end
        if (wr_en && take[e]) begin
          used_q[e] <= 1'b1;
          op_q[e]   <= ins_op_i[lane[e]];
          dst_q[e]  <= ins_dst_i[lane[e]];
          s0_q[e]   <= ins_src0_i[lane[e]];
          s1_q[e]   <= ins_src1_i[lane[e]];
          seq_q[e]  <= ins_seq_i[lane[e]];
          r0_q[e]   <= ins_rdy0_i[lane[e]] | lhit0[lane[e]];
          r1_q[e]   <= ins_rdy1_i[lane[e]] | lhit1[lane[e]];
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < ISS_W; k++) begin
      iss_op_o[k]   = op_q[slot_idx[k]];
      iss_dst_o[k]  = dst_q[slot_idx[k]];
      iss_src0_o[k] = s0_q[slot_idx[k]];
      iss_src1_o[k] = s1_q[slot_idx[k]];
      iss_seq_o[k]  = seq_q[slot_idx[k]];
    end
  end
endmodule

// File: rtl/iq_chk.sv
module iq_chk
  import iq_pkg::*;
#(
  parameter int unsigned INS_W = 4,
  parameter int unsigned ISS_W = 4,
  parameter int unsigned SEQ_W = 6
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [INS_W-1:0]            ins_valid_i,
  input logic                        full_o,
  input logic                        flush_i,
  input logic [SEQ_W-1:0]            flush_seq_i,
  input logic [ISS_W-1:0]            iss_valid_o,
  input logic [ISS_W-1:0][SEQ_W-1:0] iss_seq_o
);
  // R2
  full_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (|ins_valid_i));

  for (genvar k = 0; k + 1 < ISS_W; k++) begin : g_pair
    // R7
    slot_pack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[k+1] |-> iss_valid_o[k]);
    // R7
    slot_age_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[k+1] |-> seq_older(32'(iss_seq_o[k]), 32'(iss_seq_o[k+1]), SEQ_W));
  end

  for (genvar k = 0; k < ISS_W; k++) begin : g_slot
    // R9
    flush_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_i && iss_valid_o[k]) |->
        !seq_older(32'(flush_seq_i), 32'(iss_seq_o[k]), SEQ_W));
    // R8
    no_reissue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[k] |=> !(iss_valid_o[k] && iss_seq_o[k] == $past(iss_seq_o[k])));
  end
endmodule

bind iq_wakeup_select iq_chk #(
  .INS_W(INS_W), .ISS_W(ISS_W), .SEQ_W(SEQ_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ins_valid_i(ins_valid_i),
  .full_o     (full_o),
  .flush_i    (flush_i),
  .flush_seq_i(flush_seq_i),
  .iss_valid_o(iss_valid_o),
  .iss_seq_o  (iss_seq_o)
);

// File: tb/sim_iq_wakeup_select.sv
`timescale 1ns/1ps
module sim_iq_wakeup_select;
  localparam int DEPTH = 8, INS_W = 4, ISS_W = 4, WK_N = 2, TAG_W = 6, SEQ_W = 6;
  localparam int OP_W = iq_pkg::OP_W;
  localparam int SMOD = 1 << SEQ_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [INS_W-1:0]            ins_valid, ins_rdy0, ins_rdy1;
  logic [INS_W-1:0][OP_W-1:0]  ins_op;
  logic [INS_W-1:0][TAG_W-1:0] ins_dst, ins_src0, ins_src1;
  logic [INS_W-1:0][SEQ_W-1:0] ins_seq;
  logic                        full;
  logic [WK_N-1:0]             wk_valid, wk_load;
  logic [WK_N-1:0][TAG_W-1:0]  wk_tag;
  logic                        flush;
  logic [SEQ_W-1:0]            flush_seq;
  logic [ISS_W-1:0]            iss_valid;
  logic [ISS_W-1:0][OP_W-1:0]  iss_op;
  logic [ISS_W-1:0][TAG_W-1:0] iss_dst, iss_src0, iss_src1;
  logic [ISS_W-1:0][SEQ_W-1:0] iss_seq;

  iq_wakeup_select #(.DEPTH(DEPTH), .INS_W(INS_W), .ISS_W(ISS_W), .WK_N(WK_N),
                     .TAG_W(TAG_W), .SEQ_W(SEQ_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid), .ins_op_i(ins_op), .ins_dst_i(ins_dst),
    .ins_src0_i(ins_src0), .ins_rdy0_i(ins_rdy0), .ins_src1_i(ins_src1),
    .ins_rdy1_i(ins_rdy1), .ins_seq_i(ins_seq), .full_o(full),
    .wk_valid_i(wk_valid), .wk_load_i(wk_load), .wk_tag_i(wk_tag),
    .flush_i(flush), .flush_seq_i(flush_seq),
    .iss_valid_o(iss_valid), .iss_op_o(iss_op), .iss_dst_o(iss_dst),
    .iss_src0_o(iss_src0), .iss_src1_o(iss_src1), .iss_seq_o(iss_seq)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic m_v [DEPTH];
  logic m_r0 [DEPTH];
  logic m_r1 [DEPTH];
  int   m_seq [DEPTH];
  int   m_op [DEPTH];
  int   m_dst [DEPTH];
  int   m_s0 [DEPTH];
  int   m_s1 [DEPTH];
  logic pl_v [WK_N];
  int   pl_t [WK_N];
  logic ev [2*WK_N];
  int   et [2*WK_N];
  int   seq_ctr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  task automatic clear_in();
    ins_valid = '0; ins_rdy0 = '0; ins_rdy1 = '0; ins_op = '0; ins_dst = '0;
    ins_src0 = '0; ins_src1 = '0; ins_seq = '0;
    wk_valid = '0; wk_load = '0; wk_tag = '0; flush = 1'b0; flush_seq = '0;
  endtask

  task automatic put(input int l, input int op, input int dst, input int s0, input bit r0,
                     input int s1, input bit r1, input int seq);
    ins_valid[l] = 1'b1; ins_op[l] = OP_W'(op); ins_dst[l] = TAG_W'(dst);
    ins_src0[l] = TAG_W'(s0); ins_rdy0[l] = r0; ins_src1[l] = TAG_W'(s1);
    ins_rdy1[l] = r1; ins_seq[l] = SEQ_W'(seq);
  endtask

  task automatic bc(input int p, input int tag, input bit ld);
    wk_valid[p] = 1'b1; wk_tag[p] = TAG_W'(tag); wk_load[p] = ld;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
  endtask

  function automatic bit b_older(input int a, input int b);
    return (((a - b) % SMOD + SMOD) % SMOD) >= (SMOD / 2);
  endfunction

  function automatic bit b_match(input int tag);
    for (int j = 0; j < 2 * WK_N; j++) if (ev[j] && et[j] == tag) return 1'b1;
    return 1'b0;
  endfunction

  task automatic rnd_cycle();
    int nreq, nfree, gap, pos, best;
    bit do_flush, exp_full;
    int fs;
    bit taken [DEPTH];
    clear_in();
    gap = 0;
    for (int e = 0; e < DEPTH; e++) begin
      int g;
      g = ((seq_ctr - m_seq[e]) % SMOD + SMOD) % SMOD;
      if (m_v[e] && g > gap) gap = g;
    end
    do_flush = ($urandom % 16) == 0;
    fs = ((seq_ctr - 1 - int'($urandom % 4)) % SMOD + SMOD) % SMOD;
    if (do_flush) begin
      flush = 1'b1;
      flush_seq = SEQ_W'(fs);
    end
    pos = 0;
    if (gap < 24) begin
      for (int l = 0; l < INS_W; l++) begin
        if ($urandom % 2 == 1) begin
          put(l, int'($urandom % 4), int'($urandom % 64), int'($urandom % 16),
              bit'($urandom % 2), int'($urandom % 16), bit'($urandom % 2),
              (seq_ctr + pos) % SMOD);
          pos++;
        end
      end
    end
    for (int p = 0; p < WK_N; p++)
      if ($urandom % 2 == 1) bc(p, int'($urandom % 16), bit'($urandom % 2));
    #1;
    nreq = pos;
    nfree = 0;
    for (int e = 0; e < DEPTH; e++) if (!m_v[e]) nfree++;
    exp_full = nreq > nfree;
    chk("R2 full", 32'(full), 32'(exp_full));
    for (int e = 0; e < DEPTH; e++) taken[e] = 1'b0;
    for (int k = 0; k < ISS_W; k++) begin
      best = -1;
      for (int e = 0; e < DEPTH; e++) begin
        if (m_v[e] && m_r0[e] && m_r1[e] && !taken[e] &&
            !(do_flush && b_older(fs, m_seq[e])) &&
            (best < 0 || b_older(m_seq[e], m_seq[best]))) best = e;
      end
      chk("R7 slot valid", 32'(iss_valid[k]), 32'(best >= 0));
      if (best >= 0) begin
        taken[best] = 1'b1;
        chk("R7 slot seq", 32'(iss_seq[k]), 32'(m_seq[best]));
        chk("R10 dst", 32'(iss_dst[k]), 32'(m_dst[best]));
        chk("R10 src0", 32'(iss_src0[k]), 32'(m_s0[best]));
        chk("R10 src1", 32'(iss_src1[k]), 32'(m_s1[best]));
        chk("R10 op", 32'(iss_op[k]), 32'(m_op[best]));
      end
    end
    @(posedge clk);
    for (int p = 0; p < WK_N; p++) begin
      ev[p] = wk_valid[p] && !wk_load[p];
      et[p] = int'(wk_tag[p]);
      ev[WK_N+p] = pl_v[p];
      et[WK_N+p] = pl_t[p];
    end
    for (int e = 0; e < DEPTH; e++) begin
      if (m_v[e] && (taken[e] || (do_flush && b_older(fs, m_seq[e])))) m_v[e] = 1'b0;
      else if (m_v[e]) begin
        m_r0[e] = m_r0[e] | b_match(m_s0[e]);
        m_r1[e] = m_r1[e] | b_match(m_s1[e]);
      end
    end
    if (!do_flush && !exp_full) begin
      for (int l = 0; l < INS_W; l++) begin
        if (ins_valid[l]) begin
          for (int e = 0; e < DEPTH; e++) begin
            if (!m_v[e]) begin
              m_v[e] = 1'b1; m_seq[e] = int'(ins_seq[l]); m_op[e] = int'(ins_op[l]);
              m_dst[e] = int'(ins_dst[l]); m_s0[e] = int'(ins_src0[l]);
              m_s1[e] = int'(ins_src1[l]);
              m_r0[e] = ins_rdy0[l] | b_match(m_s0[e]);
              m_r1[e] = ins_rdy1[l] | b_match(m_s1[e]);
              break;
            end
          end
        end
      end
      seq_ctr = (seq_ctr + nreq) % SMOD;
    end
    if (do_flush) seq_ctr = (fs + 1) % SMOD;
    for (int p = 0; p < WK_N; p++) begin
      pl_v[p] = wk_valid[p] && wk_load[p];
      pl_t[p] = int'(wk_tag[p]);
    end
    #1;
  endtask

  initial begin
    do_reset();
    // R1
    chk("R1 full after reset", 32'(full), 32'(0));
    chk("R1 issue after reset", 32'(iss_valid), 32'(0));

    // R3 / R10: ready at insert
    put(0, 1, 33, 2, 1'b1, 3, 1'b1, 0);
    cyc(); clear_in(); #1;
    chk("R3 ready insert issues", 32'(iss_valid), 32'h1);
    chk("R10 dst", 32'(iss_dst[0]), 32'd33);
    chk("R10 src1", 32'(iss_src1[0]), 32'd3);
    chk("R10 op", 32'(iss_op[0]), 32'd1);
    cyc(); #1;
    chk("R8 leaves after issue", 32'(iss_valid), 32'h0);

    // R7 / R4: younger ready first, ALU wakeup
    put(0, 0, 34, 7, 1'b0, 3, 1'b1, 1);
    put(1, 0, 35, 2, 1'b1, 3, 1'b1, 2);
    cyc(); clear_in(); #1;
    chk("R7 younger ready issues", 32'(iss_valid), 32'h1);
    chk("R7 younger seq", 32'(iss_seq[0]), 32'd2);
    bc(0, 7, 1'b0);
    cyc(); clear_in(); #1;
    chk("R4 alu wake next cycle", 32'(iss_valid), 32'h1);
    chk("R4 woken seq", 32'(iss_seq[0]), 32'd1);
    cyc();

    // R5: load wakeup one cycle later
    put(0, 1, 36, 9, 1'b0, 3, 1'b1, 3);
    cyc(); clear_in();
    bc(0, 9, 1'b1);
    cyc(); clear_in(); #1;
    chk("R5 load not yet", 32'(iss_valid), 32'h0);
    cyc(); #1;
    chk("R5 load wake late", 32'(iss_valid), 32'h1);
    chk("R5 seq", 32'(iss_seq[0]), 32'd3);
    cyc();

    // R6: broadcast during insertion
    put(0, 0, 37, 11, 1'b0, 11, 1'b0, 4);
    bc(1, 11, 1'b0);
    cyc(); clear_in(); #1;
    chk("R6 same cycle wake", 32'(iss_valid), 32'h1);
    chk("R6 seq", 32'(iss_seq[0]), 32'd4);
    cyc();

    // R2 / R9: fill, refuse, flush
    for (int l = 0; l < 4; l++) put(l, 0, 40 + l, 20, 1'b0, 3, 1'b1, 5 + l);
    cyc(); clear_in();
    for (int l = 0; l < 4; l++) put(l, 0, 44 + l, 20, 1'b0, 3, 1'b1, 9 + l);
    #1 chk("R2 fits", 32'(full), 32'd0);
    cyc(); clear_in();
    put(0, 0, 50, 2, 1'b1, 3, 1'b1, 13);
    #1 chk("R2 refuse when full", 32'(full), 32'd1);
    cyc(); clear_in(); #1;
    chk("R2 refused lane absent", 32'(iss_valid), 32'h0);
    flush = 1'b1; flush_seq = 6'd7;
    #1 chk("R9 flush cycle issue", 32'(iss_valid), 32'h0);
    cyc(); clear_in();
    bc(0, 20, 1'b0);
    cyc(); clear_in(); #1;
    chk("R9 only older kept", 32'(iss_valid), 32'h7);
    chk("R7 slot0 oldest", 32'(iss_seq[0]), 32'd5);
    chk("R7 slot1", 32'(iss_seq[1]), 32'd6);
    chk("R9 flush point kept", 32'(iss_seq[2]), 32'd7);
    cyc(); #1;
    chk("R8 drained", 32'(iss_valid), 32'h0);

    // R9: insert during flush dropped
    put(0, 0, 51, 2, 1'b1, 3, 1'b1, 8);
    flush = 1'b1; flush_seq = 6'd7;
    cyc(); clear_in(); #1;
    chk("R9 insert in flush dropped", 32'(iss_valid), 32'h0);

    // random phase against model
    do_reset();
    void'($urandom(32'd1234));
    for (int e = 0; e < DEPTH; e++) begin
      m_v[e] = 1'b0; m_r0[e] = 1'b0; m_r1[e] = 1'b0; m_seq[e] = 0;
      m_op[e] = 0; m_dst[e] = 0; m_s0[e] = 0; m_s1[e] = 0;
    end
    for (int p = 0; p < WK_N; p++) begin
      pl_v[p] = 1'b0; pl_t[p] = 0;
    end
    seq_ctr = 0;
    for (int c = 0; c < 3000; c++) rnd_cycle();
    summary();
  end
endmodule